// File: doc/BRIEF.md
# Condition Register Field Unit

This block owns a 32-bit condition register split into eight 4-bit fields and applies one update command per clock. Condition bits are numbered from the most significant end: condition bit index i is register bit 31 - i, and field f covers register bits 31 - 4f down to 28 - 4f. A command can write a compare result into one field, combine two single condition bits into a third, copy one field onto another, or move selected fields in from a 32-bit operand under an 8-bit mask.

A compare looks at two 32-bit operands, or at one operand and a 16-bit immediate, in signed or unsigned mode. It produces a 4-bit result whose bits are, from the top: less-than, greater-than, equal, and a copy of the sticky summary-overflow input. The whole register is always visible on a combinational read port. Field-sized indices use the low three bits of the 5-bit index inputs.

Top module: `crf_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge the register becomes all zeros, and `cr_out` always shows the register contents.
- R2: Opcode 1 (signed compare) writes {lt, gt, eq, so} into field `cmd_dst[2:0]`, comparing `opnd_a` and the second operand as two's-complement values; exactly one of lt, gt, eq is set and the other seven fields keep their values.
- R3: Opcode 2 (unsigned compare) behaves like R2 but compares the operands as unsigned values.
- R4: With `use_imm` high, the second compare operand is `imm_val` sign-extended to 32 bits in signed mode and zero-extended in unsigned mode; with `use_imm` low it is `opnd_b`.
- R5: Bit 0 of a freshly written compare field equals `so_in` as sampled with the command.
- R6: Opcode 3 (bit logic) reads condition bits `cmd_src_a` and `cmd_src_b` and writes only condition bit `cmd_dst`, where condition bit index i means register bit 31 - i.
- R7: The bit-logic function `cmd_fn` is 0 AND, 1 OR, 2 NAND, 3 XOR, 4 NOR, 5 equivalence, 6 a AND NOT b, 7 a OR NOT b.
- R8: Opcode 4 (field copy) copies field `cmd_src_a[2:0]` into field `cmd_dst[2:0]`, leaving all other fields unchanged.
- R9: Opcode 5 (masked move) sets register bits 4i+3..4i from `opnd_a` for every set bit i of `fld_mask`, and keeps all other bits.
- R10: A clock with `cmd_valid` low, or with opcode 0, 6 or 7, leaves the register unchanged.
- R11: A command sampled at one rising edge is visible on `cr_out` right after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode (see R2, R3, R6, R8, R9, R10) |
| cmd_fn | input | 3 | Bit-logic function select |
| cmd_dst | input | 5 | Destination condition bit, or field in the low 3 bits |
| cmd_src_a | input | 5 | First source condition bit, or source field in the low 3 bits |
| cmd_src_b | input | 5 | Second source condition bit |
| opnd_a | input | 32 | First compare operand; data for masked move |
| opnd_b | input | 32 | Second compare operand |
| imm_val | input | 16 | Immediate compare operand |
| use_imm | input | 1 | Compare against the extended immediate |
| so_in | input | 1 | Summary-overflow flag |
| fld_mask | input | 8 | Masked-move field select, bit i covers bits 4i+3..4i |
| cr_out | output | 32 | Current register contents |

## Verification
The bench aims at operands that straddle the sign boundary, such as 0x80000000 against 1, where a unit that mixes up signed and unsigned ordering reports the opposite of less-than. An all-ones immediate probes the extension rule; a wrong extension turns an equal result into greater-than or less-than. Bit logic at index 0 and index 31 exposes a design that numbers bits from the least significant end, since it would flip the wrong end of the register, and masked moves with single mask bits catch a reversed field order. Idle cycles and unused opcodes carrying live operands show whether a design writes when it must not.

// File: rtl/crf_pkg.sv
// Package: shared widths, opcodes and bit-logic function codes for the
// condition register field unit. Assumes the register splits evenly into
// fields of FLD_W bits.
package crf_pkg;
    localparam int CR_W      = 32;
    localparam int FLD_W     = 4;
    localparam int N_FLD     = CR_W / FLD_W;
    localparam int BIT_IDX_W = $clog2(CR_W);
    localparam int FLD_IDX_W = $clog2(N_FLD);
    localparam int IMM_W     = 16;
    localparam int OP_W      = 3;
    localparam int FN_W      = 3;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE   = 3'd0,
        OP_CMP_S  = 3'd1,
        OP_CMP_U  = 3'd2,
        OP_BITLOG = 3'd3,
        OP_FCOPY  = 3'd4,
        OP_MMOVE  = 3'd5
    } crf_op_e;

    typedef enum logic [FN_W-1:0] {
        FN_AND  = 3'd0,
        FN_OR   = 3'd1,
        FN_NAND = 3'd2,
        FN_XOR  = 3'd3,
        FN_NOR  = 3'd4,
        FN_EQV  = 3'd5,
        FN_ANDC = 3'd6,
        FN_ORC  = 3'd7
    } crf_fn_e;
endpackage

// File: rtl/crf_compare.sv
// Module: crf_compare
// Builds the 4-bit compare field {lt, gt, eq, so} from two operands.
// Signed ordering is obtained by flipping both sign bits and reusing the
// unsigned comparator. Assumes DATA_W > IMM_BITS.
module crf_compare
    import crf_pkg::*;
#(
    parameter int DATA_W   = CR_W,
    parameter int IMM_BITS = IMM_W
) (
    input  logic [DATA_W-1:0]   lhs,
    input  logic [DATA_W-1:0]   rhs,
    input  logic [IMM_BITS-1:0] imm,
    input  logic                use_imm,
    input  logic                is_signed,
    input  logic                so,
    output logic [FLD_W-1:0]    fld
);
    localparam int EXT_W = DATA_W - IMM_BITS;
    localparam logic [DATA_W-1:0] SIGN_BIT = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] rhs_sel;
    logic [DATA_W-1:0] flip;
    logic              lt;
    logic              eq;

    // Select the second operand and derive the three ordering flags.
    always_comb begin
        rhs_sel = use_imm ? {{EXT_W{is_signed & imm[IMM_BITS-1]}}, imm} : rhs;
        flip    = is_signed ? SIGN_BIT : '0;
        lt      = (lhs ^ flip) < (rhs_sel ^ flip);
        eq      = (lhs == rhs_sel);
        fld     = {lt, ~lt & ~eq, eq, so};
    end
endmodule

// File: rtl/crf_bitop.sv
// Module: crf_bitop
// Reads two condition bits (index i = register bit CR_W-1-i) and applies
// one of eight two-input functions. Purely combinational.
module crf_bitop
    import crf_pkg::*;
(
    input  logic [CR_W-1:0]      cr,
    input  logic [BIT_IDX_W-1:0] a_idx,
    input  logic [BIT_IDX_W-1:0] b_idx,
    input  logic [FN_W-1:0]      fn,
    output logic                 bit_val
);
    localparam logic [BIT_IDX_W-1:0] TOP_IDX = BIT_IDX_W'(CR_W - 1);

    logic a;
    logic b;

    // Fetch the two source bits, numbered from the most significant end.
    always_comb begin
        a = cr[TOP_IDX - a_idx];
        b = cr[TOP_IDX - b_idx];
    end

    // Apply the selected function.
    always_comb begin
        case (fn)
            FN_AND:  bit_val = a & b;
            FN_OR:   bit_val = a | b;
            FN_NAND: bit_val = ~(a & b);
            FN_XOR:  bit_val = a ^ b;
            FN_NOR:  bit_val = ~(a | b);
            FN_EQV:  bit_val = ~(a ^ b);
            FN_ANDC: bit_val = a & ~b;
            default: bit_val = a | ~b;
        endcase
    end
endmodule

// File: rtl/crf_update.sv
// Module: crf_update
// Computes the next register value for every opcode, one slice per field.
// Unknown opcodes pass the current value through. Field indices are the
// low FLD_IDX_W bits of the index inputs.
module crf_update
    import crf_pkg::*;
(
    input  logic [CR_W-1:0]      cr,
    input  logic [OP_W-1:0]      op,
    input  logic [BIT_IDX_W-1:0] dst_idx,
    input  logic [BIT_IDX_W-1:0] src_idx,
    input  logic [FLD_W-1:0]     cmp_fld,
    input  logic                 bit_val,
    input  logic [CR_W-1:0]      opnd,
    input  logic [N_FLD-1:0]     mask,
    output logic [CR_W-1:0]      nxt
);
    logic [FLD_IDX_W-1:0] dst_f;
    logic [FLD_IDX_W-1:0] src_f;
    logic [FLD_W-1:0]     fld_arr [N_FLD];
    logic [FLD_W-1:0]     src_val;

    // Narrow the indices to field width.
    always_comb begin
        dst_f = dst_idx[FLD_IDX_W-1:0];
        src_f = src_idx[FLD_IDX_W-1:0];
    end

    // Pick the source field for a copy.
    always_comb src_val = fld_arr[src_f];

    for (genvar f = 0; f < N_FLD; f++) begin : g_fld
        localparam int LO = CR_W - FLD_W * (f + 1);
        logic [FLD_W-1:0] cur;
        logic [FLD_W-1:0] nxt_f;

        assign cur        = cr[LO +: FLD_W];
        assign fld_arr[f] = cur;

        // Next value of field f for the current opcode.
        always_comb begin
            nxt_f = cur;
            case (op)
                OP_CMP_S, OP_CMP_U: begin
                    if (dst_f == FLD_IDX_W'(f)) nxt_f = cmp_fld;
                end
                OP_FCOPY: begin
                    if (dst_f == FLD_IDX_W'(f)) nxt_f = src_val;
                end
                OP_MMOVE: begin
                    if (mask[N_FLD-1-f]) nxt_f = opnd[LO +: FLD_W];
                end
                OP_BITLOG: begin
                    for (int k = 0; k < FLD_W; k++) begin
                        if (dst_idx == BIT_IDX_W'(CR_W - 1 - LO - k)) nxt_f[k] = bit_val;
                    end
                end
                default: ;
            endcase
        end

        assign nxt[LO +: FLD_W] = nxt_f;
    end
endmodule

// File: rtl/crf_unit.sv
// Module: crf_unit (top)
// Holds the condition register and applies at most one command per clock.
// Results appear on cr_out after the edge that samples the command.
// Reset is synchronous and active low.
module crf_unit
    import crf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [OP_W-1:0]      cmd_op,
    input  logic [FN_W-1:0]      cmd_fn,
    input  logic [BIT_IDX_W-1:0] cmd_dst,
    input  logic [BIT_IDX_W-1:0] cmd_src_a,
    input  logic [BIT_IDX_W-1:0] cmd_src_b,
    input  logic [CR_W-1:0]      opnd_a,
    input  logic [CR_W-1:0]      opnd_b,
    input  logic [IMM_W-1:0]     imm_val,
    input  logic                 use_imm,
    input  logic                 so_in,
    input  logic [N_FLD-1:0]     fld_mask,
    output logic [CR_W-1:0]      cr_out
);
    logic [CR_W-1:0]  cr_q;
    logic [CR_W-1:0]  cr_nxt;
    logic [FLD_W-1:0] cmp_fld;
    logic             bit_val;
    logic             signed_cmp;

    assign signed_cmp = (cmd_op == OP_CMP_S);

    crf_compare #(.DATA_W(CR_W), .IMM_BITS(IMM_W)) u_cmp (
        .lhs       (opnd_a),
        .rhs       (opnd_b),
        .imm       (imm_val),
        .use_imm   (use_imm),
        .is_signed (signed_cmp),
        .so        (so_in),
        .fld       (cmp_fld)
    );

    crf_bitop u_bit (
        .cr      (cr_q),
        .a_idx   (cmd_src_a),
        .b_idx   (cmd_src_b),
        .fn      (cmd_fn),
        .bit_val (bit_val)
    );

    crf_update u_upd (
        .cr      (cr_q),
        .op      (cmd_op),
        .dst_idx (cmd_dst),
        .src_idx (cmd_src_a),
        .cmp_fld (cmp_fld),
        .bit_val (bit_val),
        .opnd    (opnd_a),
        .mask    (fld_mask),
        .nxt     (cr_nxt)
    );

    // Register update: clear on reset, load on a valid command.
    always_ff @(posedge clk) begin
        if (!rst_n)         cr_q <= '0;
        else if (cmd_valid) cr_q <= cr_nxt;
    end

    assign cr_out = cr_q;
endmodule

// File: rtl/crf_unit_checker.sv
// Module: crf_unit_checker
// Property checks for crf_unit, attached by bind. Captures each command
// and the prior register value, then checks the register one edge later.
module crf_unit_checker
    import crf_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [OP_W-1:0]      cmd_op,
    input logic [BIT_IDX_W-1:0] cmd_dst,
    input logic [BIT_IDX_W-1:0] cmd_src_a,
    input logic                 so_in,
    input logic [N_FLD-1:0]     fld_mask,
    input logic [CR_W-1:0]      cr_out
);
    logic                 past_ok;
    logic                 q_valid;
    logic [OP_W-1:0]      q_op;
    logic [BIT_IDX_W-1:0] q_dst;
    logic [BIT_IDX_W-1:0] q_src;
    logic                 q_so;
    logic [N_FLD-1:0]     q_mask;
    logic [CR_W-1:0]      q_cr;

    function automatic logic [FLD_W-1:0] fld_of(logic [CR_W-1:0] v, logic [BIT_IDX_W-1:0] idx);
        int sh;
        sh = CR_W - FLD_W * (int'(idx[FLD_IDX_W-1:0]) + 1);
        return FLD_W'(v >> sh);
    endfunction

    function automatic logic [CR_W-1:0] fld_bits(logic [BIT_IDX_W-1:0] idx);
        int sh;
        sh = CR_W - FLD_W * (int'(idx[FLD_IDX_W-1:0]) + 1);
        return {{(CR_W-FLD_W){1'b0}}, {FLD_W{1'b1}}} << sh;
    endfunction

    function automatic logic [CR_W-1:0] mask_bits(logic [N_FLD-1:0] m);
        logic [CR_W-1:0] r;
        for (int i = 0; i < N_FLD; i++) r[i*FLD_W +: FLD_W] = {FLD_W{m[i]}};
        return r;
    endfunction

    // Capture the command and the register value seen with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            q_valid <= 1'b0;
            q_op    <= '0;
            q_dst   <= '0;
            q_src   <= '0;
            q_so    <= 1'b0;
            q_mask  <= '0;
            q_cr    <= '0;
        end else begin
            past_ok <= 1'b1;
            q_valid <= cmd_valid;
            q_op    <= cmd_op;
            q_dst   <= cmd_dst;
            q_src   <= cmd_src_a;
            q_so    <= so_in;
            q_mask  <= fld_mask;
            q_cr    <= cr_out;
        end
    end

    logic q_cmp;
    assign q_cmp = past_ok && q_valid && (q_op == OP_CMP_S || q_op == OP_CMP_U);

    a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> cr_out == '0);

    a_r2_one_order_flag: assert property (@(posedge clk) disable iff (!rst_n)
        q_cmp |-> $countones(fld_of(cr_out, q_dst) & 4'b1110) == 1);

    a_r2_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        q_cmp |-> ((cr_out ^ q_cr) & ~fld_bits(q_dst)) == '0);

    a_r5_so_copy: assert property (@(posedge clk) disable iff (!rst_n)
        q_cmp |-> fld_of(cr_out, q_dst)[0] == q_so);

    a_r6_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && q_valid && q_op == OP_BITLOG)
        |-> ((cr_out ^ q_cr) & ~(32'h8000_0000 >> q_dst)) == '0);

    a_r8_field_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && q_valid && q_op == OP_FCOPY)
        |-> fld_of(cr_out, q_dst) == fld_of(q_cr, q_src));

    a_r9_unmasked_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && q_valid && q_op == OP_MMOVE)
        |-> ((cr_out ^ q_cr) & ~mask_bits(q_mask)) == '0);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (!q_valid || q_op == OP_IDLE || q_op > OP_MMOVE)) |-> cr_out == q_cr);
endmodule

bind crf_unit crf_unit_checker u_crf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_dst   (cmd_dst),
    .cmd_src_a (cmd_src_a),
    .so_in     (so_in),
    .fld_mask  (fld_mask),
    .cr_out    (cr_out)
);

// File: tb/crf_unit_bench.sv
`timescale 1ns/1ps
module crf_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [2:0]  cmd_fn = '0;
    logic [4:0]  cmd_dst = '0;
    logic [4:0]  cmd_src_a = '0;
    logic [4:0]  cmd_src_b = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [15:0] imm_val = '0;
    logic        use_imm = 1'b0;
    logic        so_in = 1'b0;
    logic [7:0]  fld_mask = '0;
    logic [31:0] cr_out;

    int          n_tests = 0;
    int          n_fail = 0;
    logic [31:0] exp_cr = '0;
    bit          done = 0;

    always #2 clk = ~clk;

    crf_unit u_crf_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_fn(cmd_fn), .cmd_dst(cmd_dst), .cmd_src_a(cmd_src_a),
        .cmd_src_b(cmd_src_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .imm_val(imm_val), .use_imm(use_imm), .so_in(so_in),
        .fld_mask(fld_mask), .cr_out(cr_out)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Condition bit i lives at register bit 31 - i (R6).
    function automatic logic get_cbit(logic [31:0] cr, logic [4:0] i);
        return cr[31 - i];
    endfunction

    // Field f covers register bits 31-4f .. 28-4f.
    function automatic logic [31:0] put_fld(logic [31:0] cr, logic [2:0] f, logic [3:0] v);
        int lo;
        lo = 28 - 4 * int'(f);
        for (int k = 0; k < 4; k++) cr[lo + k] = v[k];
        return cr;
    endfunction

    function automatic logic [3:0] get_fld(logic [31:0] cr, logic [2:0] f);
        return cr[28 - 4 * int'(f) +: 4];
    endfunction

    // Next register value from the requirements.
    function automatic logic [31:0] model(logic [31:0] cr);
        logic [31:0] bv;
        logic        lt, gt, eq, a, b, r;
        logic [31:0] res;
        res = cr;
        case (cmd_op)
            3'd1, 3'd2: begin
                if (use_imm) bv = (cmd_op == 3'd1) ? {{16{imm_val[15]}}, imm_val} : {16'h0, imm_val};
                else         bv = opnd_b;
                if (cmd_op == 3'd1) begin
                    lt = $signed(opnd_a) < $signed(bv);
                    gt = $signed(opnd_a) > $signed(bv);
                end else begin
                    lt = opnd_a < bv;
                    gt = opnd_a > bv;
                end
                eq  = (opnd_a == bv);
                res = put_fld(cr, cmd_dst[2:0], {lt, gt, eq, so_in});
            end
            3'd3: begin
                a = get_cbit(cr, cmd_src_a);
                b = get_cbit(cr, cmd_src_b);
                case (cmd_fn)
                    3'd0: r = a & b;
                    3'd1: r = a | b;
                    3'd2: r = !(a & b);
                    3'd3: r = a ^ b;
                    3'd4: r = !(a | b);
                    3'd5: r = (a == b);
                    3'd6: r = a & !b;
                    default: r = a | !b;
                endcase
                res[31 - cmd_dst] = r;
            end
            3'd4: res = put_fld(cr, cmd_dst[2:0], get_fld(cr, cmd_src_a[2:0]));
            3'd5: for (int i = 0; i < 8; i++) if (fld_mask[i]) res[4*i +: 4] = opnd_a[4*i +: 4];
            default: ;
        endcase
        return res;
    endfunction

    // Drive one cycle's inputs (at a falling edge), check before and after the rising edge.
    task automatic step(string tag, logic v);
        logic [31:0] nxt;
        cmd_valid = v;
        nxt = v ? model(exp_cr) : exp_cr;
        #1;
        check("R11 (not before edge)", cr_out, exp_cr);
        @(posedge clk);
        @(negedge clk);
        check(tag, cr_out, nxt);
        exp_cr    = nxt;
        cmd_valid = 1'b0;
    endtask

    task automatic set_cmd(logic [2:0] op, logic [2:0] fn, logic [4:0] d, logic [4:0] a,
                           logic [4:0] b, logic [31:0] x, logic [31:0] y,
                           logic [15:0] im, logic ui, logic so, logic [7:0] m);
        cmd_op = op; cmd_fn = fn; cmd_dst = d; cmd_src_a = a; cmd_src_b = b;
        opnd_a = x; opnd_b = y; imm_val = im; use_imm = ui; so_in = so; fld_mask = m;
    endtask

    initial begin
        int unsigned seed_use;
        seed_use = $urandom(32'd7351);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset value", cr_out, 32'h0);
        rst_n = 1'b1;

        // R9 full and single-field masked moves
        set_cmd(3'd5, 0, 0, 0, 0, 32'h1234_5678, 0, 0, 0, 0, 8'hFF); step("R9 full mask", 1);
        check("R9 value", cr_out, 32'h1234_5678);
        set_cmd(3'd5, 0, 0, 0, 0, 32'hABCD_EF00, 0, 0, 0, 0, 8'h01); step("R9 low field only", 1);
        check("R9 low field", cr_out, 32'h1234_5670);

        // R2 / R3 sign boundary
        set_cmd(3'd1, 0, 5'd0, 0, 0, 32'h8000_0000, 32'd1, 0, 0, 0, 0); step("R2 signed lt", 1);
        check("R2 field0 lt", {28'h0, get_fld(cr_out, 3'd0)}, 32'h8);
        set_cmd(3'd2, 0, 5'd7, 0, 0, 32'h8000_0000, 32'd1, 0, 0, 0, 0); step("R3 unsigned gt", 1);
        check("R3 field7 gt", {28'h0, get_fld(cr_out, 3'd7)}, 32'h4);
        set_cmd(3'd1, 0, 5'd3, 0, 0, 32'h55, 32'h55, 0, 0, 1, 0); step("R5 equal with so", 1);
        check("R5 field3", {28'h0, get_fld(cr_out, 3'd3)}, 32'h3);

        // R4 immediate extension
        set_cmd(3'd1, 0, 5'd1, 0, 0, 32'hFFFF_FFFF, 0, 16'hFFFF, 1, 0, 0); step("R4 signed imm", 1);
        check("R4 signed eq", {28'h0, get_fld(cr_out, 3'd1)}, 32'h2);
        set_cmd(3'd2, 0, 5'd1, 0, 0, 32'hFFFF_FFFF, 0, 16'hFFFF, 1, 0, 0); step("R4 unsigned imm", 1);
        check("R4 unsigned gt", {28'h0, get_fld(cr_out, 3'd1)}, 32'h4);

        // R6 / R7 edge bit indices
        set_cmd(3'd3, 3'd7, 5'd0, 5'd31, 5'd31, 0, 0, 0, 0, 0, 0); step("R6 dst bit 0 (msb)", 1);
        set_cmd(3'd3, 3'd4, 5'd31, 5'd0, 5'd0, 0, 0, 0, 0, 0, 0); step("R7 nor into bit 31", 1);

        // R8 field copy
        set_cmd(3'd4, 0, 5'd0, 5'd7, 0, 0, 0, 0, 0, 0, 0); step("R8 copy 7 to 0", 1);

        // R10 idle and unused opcodes
        set_cmd(3'd5, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 8'hFF); step("R10 valid low", 0);
        set_cmd(3'd6, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 8'hFF); step("R10 opcode 6", 1);
        set_cmd(3'd0, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 8'hFF); step("R10 opcode 0", 1);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic [2:0]  op;
            string       tag;
            op = 3'($urandom_range(0, 7));
            set_cmd(op, 3'($urandom), 5'($urandom), 5'($urandom), 5'($urandom),
                    ($urandom_range(0, 3) == 0) ? 32'h8000_0000 : $urandom,
                    ($urandom_range(0, 3) == 0) ? opnd_a : $urandom,
                    16'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
            case (op)
                3'd1: tag = use_imm ? "R4 random signed imm" : "R2 random signed";
                3'd2: tag = use_imm ? "R4 random unsigned imm" : "R3 random unsigned";
                3'd3: tag = "R7 random bit logic";
                3'd4: tag = "R8 random copy";
                3'd5: tag = "R9 random masked move";
                default: tag = "R10 random no-op";
            endcase
            step(tag, ($urandom_range(0, 9) != 0));
        end

        // R1 reset after activity
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 reset after use", cr_out, 32'h0);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule